// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO with Mailbox

This block links two clock domains, port A and port B, through a pair of 36-bit first-in first-out queues that run in opposite directions. Words written at port A are read at port B, and words written at port B are read at port A. Each port has its own free-running clock. The two clocks may be unrelated or may be the same clock. A port access happens on the rising edge of that port's clock when both chip select and enable are high. A direction input chooses between push and pop, and a mailbox input sends the access to a one-word side register instead of the queue.

Every port reports full and almost-full for the queue it feeds. It reports empty and almost-empty for the queue it drains. All of these flags are registered in that port's own clock. The almost thresholds come from an offset that is captured during reset from a two-bit select. Each direction also has a single-word mailbox that bypasses its queue. The mailbox raises a waiting flag at the receiving port and a busy flag at the sending port.

The 36-bit word is treated as four 9-bit lanes. Each lane holds eight data bits and one parity bit. A port can regenerate the parity bits of the words it writes. Every port checks the parity of the word it reads and raises a flag on a mismatch, without altering the data.

Top module: `bififo_top`

## Requirements
- R1: Each direction delivers the words it accepts in write order and holds up to 64 words.
- R2: An access takes place only when chip select and enable are both high at the port's rising clock edge. The direction input set to 1 pushes and set to 0 pops. The mailbox input set to 1 sends the access to the mailbox instead of the queue.
- R3: A push while the port shows full is dropped. A pop while the port shows empty leaves the read data and the queue contents unchanged.
- R4: Once both clocks have run six idle cycles, full at the writing port equals (stored == 64) and empty at the reading port equals (stored == 0). The flags never report room or data that does not exist.
- R5: Almost-full is high when the free slots are at or below the offset. Almost-empty is high when the stored words are at or below the offset. Select values 0, 1, 2 and 3, sampled while reset is high, give offsets 2, 4, 8 and 16.
- R6: A mailbox write raises busy at the sending port and waiting at the receiving port. A mailbox read returns the word and clears both flags. A mailbox write while busy is dropped, and a mailbox read with nothing waiting leaves the read data unchanged.
- R7: Mailbox traffic neither adds, removes nor reorders queue words.
- R8: Lane k uses bits 9k+7..9k as data and bit 9k+8 as parity. The parity-error output of a port is high when any lane of the word on its read data has a one-count of the wrong sense. When the odd/even select is 1 the one-count must be odd, and when it is 0 the one-count must be even. The output is low until the first read after reset, and data passes through the check unaltered.
- R9: With a port's generate input high, every word that port writes, to the queue or the mailbox, has each lane's parity bit replaced so the lane meets the selected sense. With the input low, the word is stored as given.
- R10: Reset clears both queues and both mailboxes. It sets empty and almost-empty high and full, almost-full, busy, waiting and parity-error low.
- R11: With both ports pushing and popping at once on unrelated clocks, no word is lost, duplicated or reordered in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| fs_sel | input | 2 | Offset select, captured while reset is high |
| odd_sel | input | 1 | Parity sense: 1 odd, 0 even |
| a_cs | input | 1 | Port A chip select |
| a_wr | input | 1 | Port A direction: 1 push, 0 pop |
| a_en | input | 1 | Port A enable |
| a_mb | input | 1 | Port A mailbox select |
| a_gen | input | 1 | Port A parity generation enable |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A read data |
| a_full | output | 1 | A-to-B queue full |
| a_afull | output | 1 | A-to-B queue almost full |
| a_empty | output | 1 | B-to-A queue empty |
| a_aempty | output | 1 | B-to-A queue almost empty |
| a_mb_wait | output | 1 | Word waiting in the B-to-A mailbox |
| a_mb_busy | output | 1 | A-to-B mailbox still occupied |
| a_perr | output | 1 | Parity error on port A read data |
| b_cs | input | 1 | Port B chip select |
| b_wr | input | 1 | Port B direction: 1 push, 0 pop |
| b_en | input | 1 | Port B enable |
| b_mb | input | 1 | Port B mailbox select |
| b_gen | input | 1 | Port B parity generation enable |
| b_din | input | 36 | Port B write data |
| b_dout | output | 36 | Port B read data |
| b_full | output | 1 | B-to-A queue full |
| b_afull | output | 1 | B-to-A queue almost full |
| b_empty | output | 1 | A-to-B queue empty |
| b_aempty | output | 1 | A-to-B queue almost empty |
| b_mb_wait | output | 1 | Word waiting in the A-to-B mailbox |
| b_mb_busy | output | 1 | B-to-A mailbox still occupied |
| b_perr | output | 1 | Parity error on port B read data |

## Verification
For every offset select, the bench fills each queue one word at a time to 64 and then drains it, checking all four flags at every fill level. A design with an off-by-one in the level arithmetic, or in the wrap bit of a pointer, shows its flags one level early or late, or shows full at the wrong count. The bench pushes into a full queue and pops from an empty one. A design that drops the guard would return a stale or overwritten word, or corrupt the order of the words that follow. The mailbox is written twice before it is read, and it is read when empty. A mailbox with a broken handshake would hand over the second word or leave its flags stuck. A final phase runs both directions at once on unrelated clocks. It exposes pointer crossings that are not Gray-coded or not synchronized, which show up as lost or repeated words.

// File: rtl/bififo_pkg.sv
package bififo_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {SRC_NONE, SRC_FIFO, SRC_MBOX} rd_src_t;

  function automatic int unsigned offset_of(input logic [1:0] sel);
    return 32'd2 << sel;
  endfunction
endpackage

// File: rtl/bififo_sync.sv
module bififo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/bififo_fifo.sv
module bififo_fifo #(
  parameter int W  = 36,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          push_req,
  input  logic [W-1:0]  wdata,
  input  logic [AW:0]   wr_off,
  output logic          full,
  output logic          afull,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          pop_req,
  output logic [W-1:0]  rdata,
  input  logic [AW:0]   rd_off,
  output logic          empty,
  output logic          aempty
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_s, wgray_s, rsync_bin, wsync_bin;
  logic [PW-1:0] wbin_nx, rbin_nx, wlevel_nx, rlevel_nx;
  logic          push, pop;

  bififo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s));
  bififo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s));

  assign rsync_bin = g2b(rgray_s);
  assign wsync_bin = g2b(wgray_s);

  // write domain
  assign push      = push_req & ~full;
  assign wbin_nx   = wbin + PW'(push);
  assign wlevel_nx = wbin_nx - rsync_bin;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= b2g(wbin_nx);
      full  <= (wlevel_nx == DEPTH_V);
      afull <= ((DEPTH_V - wlevel_nx) <= wr_off);
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wdata;
  end

  // read domain
  assign pop       = pop_req & ~empty;
  assign rbin_nx   = rbin + PW'(pop);
  assign rlevel_nx = wsync_bin - rbin_nx;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= b2g(rbin_nx);
      empty  <= (rlevel_nx == '0);
      aempty <= (rlevel_nx <= rd_off);
    end
  end

  always_ff @(posedge rclk) begin
    if (pop) rdata <= mem[rbin[AW-1:0]];
  end

  // R4
  level_bound_w_chk: assert property (@(posedge wclk) disable iff (wrst)
    (PW'(wbin - rsync_bin) <= DEPTH_V));

  // R4
  level_bound_r_chk: assert property (@(posedge rclk) disable iff (rrst)
    (PW'(wsync_bin - rbin) <= DEPTH_V));
endmodule

// File: rtl/bififo_mbox.sv
module bififo_mbox #(
  parameter int W = 36
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         put,
  input  logic [W-1:0] wdata,
  output logic         busy,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         take,
  output logic [W-1:0] rdata,
  output logic         waiting
);
  logic         wtog, rtog, wtog_s, rtog_s;
  logic [W-1:0] hold;

  bififo_sync #(.W(1)) u_w2r (.clk(rclk), .rst(rrst), .d(wtog), .q(wtog_s));
  bififo_sync #(.W(1)) u_r2w (.clk(wclk), .rst(wrst), .d(rtog), .q(rtog_s));

  assign busy    = wtog ^ rtog_s;
  assign waiting = wtog_s ^ rtog;
  assign rdata   = hold;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wtog <= 1'b0;
      hold <= '0;
    end else if (put && !busy) begin
      wtog <= ~wtog;
      hold <= wdata;
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst)                 rtog <= 1'b0;
    else if (take && waiting) rtog <= ~rtog;
  end

  // R6
  mb_load_chk: assert property (@(posedge wclk) disable iff (wrst)
    (put && !busy) |=> busy);

  // R6
  mb_take_chk: assert property (@(posedge rclk) disable iff (rrst)
    (take && waiting) |=> !waiting);
endmodule

// File: rtl/bififo_port.sv
module bififo_port
  import bififo_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int AW    = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs,
  input  logic                  wr,
  input  logic                  en,
  input  logic                  mb,
  input  logic                  gen,
  input  logic                  odd,
  input  logic [1:0]            fs,
  input  logic [BYTES*LANE_W-1:0] din,
  input  logic [BYTES*LANE_W-1:0] fifo_q,
  input  logic [BYTES*LANE_W-1:0] mb_q,
  input  logic                  empty,
  input  logic                  mb_wait,
  output logic                  push_req,
  output logic                  pop_req,
  output logic                  mb_put,
  output logic                  mb_take,
  output logic [BYTES*LANE_W-1:0] wdata,
  output logic [AW:0]           off,
  output logic [BYTES*LANE_W-1:0] dout,
  output logic                  perr
);
  localparam int W = BYTES * LANE_W;

  logic             go;
  logic [BYTES-1:0] bad;
  logic [W-1:0]     mbcap;
  rd_src_t          src;

  assign go       = cs & en;
  assign push_req = go &  wr & ~mb;
  assign pop_req  = go & ~wr & ~mb;
  assign mb_put   = go &  wr &  mb;
  assign mb_take  = go & ~wr &  mb;

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    logic [7:0] dbyte;
    assign dbyte = din[k*LANE_W +: 8];
    assign wdata[k*LANE_W +: 8]  = dbyte;
    assign wdata[k*LANE_W + 8]   = gen ? ((^dbyte) ^ odd) : din[k*LANE_W + 8];
    assign bad[k] = (^dout[k*LANE_W +: LANE_W]) != odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off   <= (AW+1)'(offset_of(fs));
      src   <= SRC_NONE;
      mbcap <= '0;
    end else if (pop_req && !empty) begin
      src <= SRC_FIFO;
    end else if (mb_take && mb_wait) begin
      src   <= SRC_MBOX;
      mbcap <= mb_q;
    end
  end

  assign dout = (src == SRC_FIFO) ? fifo_q : mbcap;
  assign perr = (src != SRC_NONE) && (|bad);

  // R5
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(off));
endmodule

// File: rtl/bififo_top.sv
module bififo_top #(
  parameter int BYTES = 4,
  parameter int AW    = 6,
  localparam int W    = BYTES * 9
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst,
  input  logic [1:0]   fs_sel,
  input  logic         odd_sel,
  input  logic         a_cs,
  input  logic         a_wr,
  input  logic         a_en,
  input  logic         a_mb,
  input  logic         a_gen,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_full,
  output logic         a_afull,
  output logic         a_empty,
  output logic         a_aempty,
  output logic         a_mb_wait,
  output logic         a_mb_busy,
  output logic         a_perr,
  input  logic         b_cs,
  input  logic         b_wr,
  input  logic         b_en,
  input  logic         b_mb,
  input  logic         b_gen,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] b_dout,
  output logic         b_full,
  output logic         b_afull,
  output logic         b_empty,
  output logic         b_aempty,
  output logic         b_mb_wait,
  output logic         b_mb_busy,
  output logic         b_perr
);
  logic         a_push, a_pop, a_put, a_take, b_push, b_pop, b_put, b_take;
  logic [W-1:0] a_wdata, b_wdata, ab_q, ba_q, ab_mbq, ba_mbq;
  logic [AW:0]  a_off, b_off;

  bififo_port #(.BYTES(BYTES), .AW(AW)) u_port_a (
    .clk(clk_a), .rst(rst), .cs(a_cs), .wr(a_wr), .en(a_en), .mb(a_mb),
    .gen(a_gen), .odd(odd_sel), .fs(fs_sel), .din(a_din),
    .fifo_q(ba_q), .mb_q(ba_mbq), .empty(a_empty), .mb_wait(a_mb_wait),
    .push_req(a_push), .pop_req(a_pop), .mb_put(a_put), .mb_take(a_take),
    .wdata(a_wdata), .off(a_off), .dout(a_dout), .perr(a_perr));

  bififo_port #(.BYTES(BYTES), .AW(AW)) u_port_b (
    .clk(clk_b), .rst(rst), .cs(b_cs), .wr(b_wr), .en(b_en), .mb(b_mb),
    .gen(b_gen), .odd(odd_sel), .fs(fs_sel), .din(b_din),
    .fifo_q(ab_q), .mb_q(ab_mbq), .empty(b_empty), .mb_wait(b_mb_wait),
    .push_req(b_push), .pop_req(b_pop), .mb_put(b_put), .mb_take(b_take),
    .wdata(b_wdata), .off(b_off), .dout(b_dout), .perr(b_perr));

  bififo_fifo #(.W(W), .AW(AW)) u_fifo_ab (
    .wclk(clk_a), .wrst(rst), .push_req(a_push), .wdata(a_wdata),
    .wr_off(a_off), .full(a_full), .afull(a_afull),
    .rclk(clk_b), .rrst(rst), .pop_req(b_pop), .rdata(ab_q),
    .rd_off(b_off), .empty(b_empty), .aempty(b_aempty));

  bififo_fifo #(.W(W), .AW(AW)) u_fifo_ba (
    .wclk(clk_b), .wrst(rst), .push_req(b_push), .wdata(b_wdata),
    .wr_off(b_off), .full(b_full), .afull(b_afull),
    .rclk(clk_a), .rrst(rst), .pop_req(a_pop), .rdata(ba_q),
    .rd_off(a_off), .empty(a_empty), .aempty(a_aempty));

  bififo_mbox #(.W(W)) u_mbox_ab (
    .wclk(clk_a), .wrst(rst), .put(a_put), .wdata(a_wdata), .busy(a_mb_busy),
    .rclk(clk_b), .rrst(rst), .take(b_take), .rdata(ab_mbq), .waiting(b_mb_wait));

  bififo_mbox #(.W(W)) u_mbox_ba (
    .wclk(clk_b), .wrst(rst), .put(b_put), .wdata(b_wdata), .busy(b_mb_busy),
    .rclk(clk_a), .rrst(rst), .take(a_take), .rdata(ba_mbq), .waiting(a_mb_wait));
endmodule

// File: tb/test_bififo_top.sv
`timescale 1ns/1ps
module test_bififo_top;
  localparam int DEPTH = 64;
  localparam int NSTREAM = 150;

  logic clk_a = 1'b0, clk_b = 1'b0, rst = 1'b1;
  logic [1:0] fs_sel = 2'd0;
  logic odd_sel = 1'b1;
  logic a_cs = 0, a_wr = 0, a_en = 0, a_mb = 0, a_gen = 0;
  logic b_cs = 0, b_wr = 0, b_en = 0, b_mb = 0, b_gen = 0;
  logic [35:0] a_din = '0, b_din = '0, a_dout, b_dout;
  logic a_full, a_afull, a_empty, a_aempty, a_mb_wait, a_mb_busy, a_perr;
  logic b_full, b_afull, b_empty, b_aempty, b_mb_wait, b_mb_busy, b_perr;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [35:0] q_ab[$], q_ba[$];

  always #5 clk_a = ~clk_a;   // 100 MHz
  always #7 clk_b = ~clk_b;   // unrelated second clock

  bififo_top i_bififo_top (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .fs_sel(fs_sel), .odd_sel(odd_sel),
    .a_cs(a_cs), .a_wr(a_wr), .a_en(a_en), .a_mb(a_mb), .a_gen(a_gen), .a_din(a_din),
    .a_dout(a_dout), .a_full(a_full), .a_afull(a_afull), .a_empty(a_empty),
    .a_aempty(a_aempty), .a_mb_wait(a_mb_wait), .a_mb_busy(a_mb_busy), .a_perr(a_perr),
    .b_cs(b_cs), .b_wr(b_wr), .b_en(b_en), .b_mb(b_mb), .b_gen(b_gen), .b_din(b_din),
    .b_dout(b_dout), .b_full(b_full), .b_afull(b_afull), .b_empty(b_empty),
    .b_aempty(b_aempty), .b_mb_wait(b_mb_wait), .b_mb_busy(b_mb_busy), .b_perr(b_perr));

  function automatic logic [35:0] mk(input int i);
    logic [35:0] w;
    for (int k = 0; k < 4; k++) begin
      w[9*k +: 8] = 8'(i * 29 + k * 53 + 7);
      w[9*k + 8]  = 1'((i >> k) & 1);
    end
    return w;
  endfunction

  function automatic logic [35:0] regen(input logic [35:0] w, input logic odd);
    logic [35:0] r = w;
    for (int k = 0; k < 4; k++) r[9*k + 8] = (^w[9*k +: 8]) ^ odd;
    return r;
  endfunction

  function automatic logic bad_par(input logic [35:0] w, input logic odd);
    logic b = 1'b0;
    for (int k = 0; k < 4; k++) if ((^w[9*k +: 9]) != odd) b = 1'b1;
    return b;
  endfunction

  function automatic logic [35:0] stored(input int dir, input logic [35:0] w);
    logic g = (dir == 0) ? a_gen : b_gen;
    return g ? regen(w, odd_sel) : w;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int p);
    if (p == 0) @(negedge clk_a); else @(negedge clk_b);
  endtask

  task automatic set_ctl(input int p, input logic cs, en, wr, mb, input logic [35:0] d);
    if (p == 0) begin a_cs = cs; a_en = en; a_wr = wr; a_mb = mb; a_din = d; end
    else        begin b_cs = cs; b_en = en; b_wr = wr; b_mb = mb; b_din = d; end
  endtask

  task automatic port_op(input int p, input logic cs, en, wr, mb, input logic [35:0] d);
    wait_neg(p);
    set_ctl(p, cs, en, wr, mb, d);
    wait_neg(p);
    set_ctl(p, 0, 0, 0, 0, '0);
  endtask

  function automatic logic [35:0] dout_of(input int p);
    return (p == 0) ? a_dout : b_dout;
  endfunction
  function automatic logic perr_of(input int p);
    return (p == 0) ? a_perr : b_perr;
  endfunction
  // {full, afull at writer ; empty, aempty at reader} for direction dir
  function automatic logic [3:0] flags(input int dir);
    return (dir == 0) ? {a_full, a_afull, b_empty, b_aempty}
                      : {b_full, b_afull, a_empty, a_aempty};
  endfunction
  function automatic logic [3:0] exp_flags(input int n, input int off);
    return {n == DEPTH, (DEPTH - n) <= off, n == 0, n <= off};
  endfunction

  task automatic settle();
    repeat (6) @(negedge clk_a);
    repeat (6) @(negedge clk_b);
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk_b);
    fs_sel = sel;
    rst = 1'b1;
    set_ctl(0, 0, 0, 0, 0, '0);
    set_ctl(1, 0, 0, 0, 0, '0);
    repeat (5) @(negedge clk_b);
    rst = 1'b0;
    q_ab.delete();
    q_ba.delete();
    settle();
  endtask

  task automatic chk_reset_state();
    // R10
    chk("R10 port A flags", 36'({a_full, a_afull, a_empty, a_aempty, a_mb_wait, a_mb_busy, a_perr}),
        36'(7'b0011000));
    chk("R10 port B flags", 36'({b_full, b_afull, b_empty, b_aempty, b_mb_wait, b_mb_busy, b_perr}),
        36'(7'b0011000));
  endtask

  task automatic fill_drain(input int dir, input int off, input int seed);
    logic [35:0] w, e, last;
    int rd = 1 - dir;
    for (int n = 1; n <= DEPTH; n++) begin
      w = mk(seed + n);
      port_op(dir, 1, 1, 1, 0, w);
      if (dir == 0) q_ab.push_back(stored(0, w)); else q_ba.push_back(stored(1, w));
      settle();
      chk($sformatf("R4 R5 fill dir=%0d n=%0d", dir, n), 36'(flags(dir)), 36'(exp_flags(n, off)));
    end
    // R3: push into a full queue is dropped
    port_op(dir, 1, 1, 1, 0, mk(seed + 500));
    settle();
    chk($sformatf("R3 full push dir=%0d", dir), 36'(flags(dir)), 36'(exp_flags(DEPTH, off)));
    for (int n = DEPTH - 1; n >= 0; n--) begin
      port_op(rd, 1, 1, 0, 0, '0);
      e = (dir == 0) ? q_ab.pop_front() : q_ba.pop_front();
      chk($sformatf("R1 order dir=%0d n=%0d", dir, n), dout_of(rd), e);
      chk($sformatf("R8 perr dir=%0d n=%0d", dir, n), 36'(perr_of(rd)), 36'(bad_par(e, odd_sel)));
      settle();
      chk($sformatf("R4 R5 drain dir=%0d n=%0d", dir, n), 36'(flags(dir)), 36'(exp_flags(n, off)));
    end
    // R3: pop from an empty queue leaves data alone
    last = dout_of(rd);
    port_op(rd, 1, 1, 0, 0, '0);
    chk($sformatf("R3 empty pop dir=%0d", dir), dout_of(rd), last);
    settle();
    chk($sformatf("R3 empty flags dir=%0d", dir), 36'(flags(dir)), 36'(exp_flags(0, off)));
  endtask

  task automatic port_stream(input int p);
    int sent = 0, got = 0;
    bit pend = 0, turn = 0, rd_ok, wr_ok;
    logic [35:0] w, e;
    while (sent < NSTREAM || got < NSTREAM) begin
      wait_neg(p);
      if (pend) begin
        e = (p == 0) ? q_ba.pop_front() : q_ab.pop_front();
        // R11
        chk($sformatf("R11 stream port=%0d word=%0d", p, got), dout_of(p), e);
        chk($sformatf("R8 stream perr port=%0d", p), 36'(perr_of(p)), 36'(bad_par(e, odd_sel)));
        got++;
      end
      pend  = 0;
      rd_ok = (got < NSTREAM) && !((p == 0) ? a_empty : b_empty);
      wr_ok = (sent < NSTREAM) && !((p == 0) ? a_full : b_full);
      if (rd_ok && (turn || !wr_ok)) begin
        set_ctl(p, 1, 1, 0, 0, '0);
        pend = 1;
      end else if (wr_ok) begin
        w = mk(7000 + p * 1000 + sent);
        set_ctl(p, 1, 1, 1, 0, w);
        if (p == 0) q_ab.push_back(stored(0, w)); else q_ba.push_back(stored(1, w));
        sent++;
      end else begin
        set_ctl(p, 0, 0, 0, 0, '0);
      end
      turn = ~turn;
    end
    wait_neg(p);
    set_ctl(p, 0, 0, 0, 0, '0);
  endtask

  initial begin : main
    logic [35:0] w1, m1, m2, e;
    // R10: state straight out of the first reset
    do_reset(2'd0);
    chk_reset_state();

    // R1 R3 R4 R5 R8 R9 sweep over every offset select, both directions
    for (int sel = 0; sel < 4; sel++) begin
      odd_sel = sel[0];
      a_gen   = sel[1];
      b_gen   = ~sel[1];
      do_reset(2'(sel));
      chk_reset_state();
      fill_drain(0, 2 << sel, sel * 300);
      fill_drain(1, 2 << sel, sel * 300 + 150);
    end

    // R2: cs or en low blocks every access
    odd_sel = 1'b1; a_gen = 1'b0; b_gen = 1'b1;
    do_reset(2'd1);
    w1 = mk(41);
    port_op(0, 1, 0, 1, 0, w1);
    port_op(0, 0, 1, 1, 0, w1);
    port_op(0, 1, 0, 1, 1, w1);
    settle();
    chk("R2 gated push", 36'({b_empty, b_mb_wait}), 36'(2'b10));
    port_op(0, 1, 1, 1, 0, w1);
    settle();
    port_op(1, 0, 1, 0, 0, '0);
    port_op(1, 1, 0, 0, 0, '0);
    settle();
    chk("R2 gated pop", 36'(b_empty), 36'(1'b0));
    port_op(1, 1, 1, 0, 0, '0);
    chk("R2 real pop", b_dout, w1);

    // R6 R7 mailbox A to B next to queue traffic
    m1 = mk(61); m2 = mk(62);
    port_op(0, 1, 1, 1, 0, w1);
    port_op(0, 1, 1, 1, 1, m1);
    settle();
    chk("R6 mailbox flags set", 36'({a_mb_busy, b_mb_wait}), 36'(2'b11));
    port_op(0, 1, 1, 1, 1, m2);
    port_op(1, 1, 1, 0, 1, '0);
    chk("R6 mailbox word", b_dout, m1);
    chk("R8 mailbox perr", 36'(b_perr), 36'(bad_par(m1, odd_sel)));
    settle();
    chk("R6 mailbox flags clear", 36'({a_mb_busy, b_mb_wait}), 36'(2'b00));
    port_op(1, 1, 1, 0, 1, '0);
    chk("R6 empty mailbox read", b_dout, m1);
    port_op(1, 1, 1, 0, 0, '0);
    chk("R7 queue after mailbox", b_dout, w1);
    settle();
    chk("R7 queue empty after mailbox", 36'(b_empty), 36'(1'b1));

    // R6 R9 mailbox B to A with generated parity
    port_op(1, 1, 1, 1, 1, m2);
    settle();
    chk("R6 mailbox B flags", 36'({b_mb_busy, a_mb_wait}), 36'(2'b11));
    port_op(0, 1, 1, 0, 1, '0);
    e = regen(m2, odd_sel);
    chk("R9 mailbox regen", a_dout, e);
    chk("R9 mailbox perr", 36'(a_perr), 36'(1'b0));

    // R10: reset in the middle of traffic empties everything
    port_op(0, 1, 1, 1, 0, mk(81));
    port_op(1, 1, 1, 1, 0, mk(82));
    port_op(0, 1, 1, 1, 1, mk(83));
    settle();
    do_reset(2'd2);
    chk_reset_state();

    // R11: both directions at once
    a_gen = 1'b1; b_gen = 1'b0; odd_sel = 1'b0;
    do_reset(2'd0);
    fork
      port_stream(0);
      port_stream(1);
    join
    settle();
    chk("R11 both empty at end", 36'({a_empty, b_empty}), 36'(2'b11));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_a);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule